// File: doc/BRIEF.md
# Checked Adder Using a Times-Three Arithmetic Code

This block adds two unsigned data words and checks the addition with an arithmetic code instead of a duplicate adder. Each operand is mapped to three times its value: the block forms a left-shifted copy (twice the value) and adds the original to it, in an adder two bits wider than the data. The two codewords are summed in a code-width adder. The code survives addition: three times b plus three times c equals three times (b + c). A sum with no fault is therefore a multiple of three, and a checker tests exactly that.

The divisibility test uses no divider. Bit positions of even index weigh 1 modulo 3 and positions of odd index weigh 2 (which equals -1), so the residue is a small weighted bit count. A single changed bit moves the value by a power of two, and a power of two is never a multiple of three. Every single-bit fault in the sum is therefore caught. This is why the multiplier must not be a power of two. A fault-injection path forces chosen sum bits to 0 or 1 before the checker sees them, so that the checker can be exercised in place.

The outputs are:
- the code-width sum with its carry-out;
- the decoded data sum, which is the checked word divided by three;
- an error flag;
- an overflow flag.

All outputs are registered, one clock after the operands.

Top module: `an3_checked_adder`

## Requirements
- R1: With `op_b` = 0 and no fault masks, the registered `{code_carry, code_sum}` equals 3 × `op_a` for every `op_a` (for example, 1 gives 000011 and 15 gives 101101).
- R2: With no fault masks, `{code_carry, code_sum}` equals 3 × `op_a` + 3 × `op_b`. `code_sum` holds bits 5..0 of that value and `code_carry` holds bit 6.
- R3: With both fault masks zero, `err` is 0 for every operand pair.
- R4: `err` is 1 exactly when the checked word `{code_carry, code_sum}` is not a multiple of 3. Example: operands 6 and 1 with `stuck1_mask` = 000010 give `code_sum` 010111 (23), and `err` is 1.
- R5: Any mask setting that changes exactly one bit of the 6-bit sum makes `err` 1.
- R6: `code_sum` = (true sum & ~`stuck0_mask`) | `stuck1_mask`. Stuck-at-1 wins where both masks select a bit. `code_carry` is never masked.
- R7: `dec_sum` equals floor(`{code_carry, code_sum}` / 3). With no fault it equals `op_a` + `op_b`.
- R8: `ovf` is 1 exactly when `dec_sum` exceeds 15, the largest value a data word can hold.
- R9: Outputs change one clock edge after the inputs. While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 4 | First data operand, unsigned |
| op_b | input | 4 | Second data operand, unsigned |
| stuck0_mask | input | 6 | Sum bits forced to 0 |
| stuck1_mask | input | 6 | Sum bits forced to 1 (wins over stuck0_mask) |
| code_sum | output | 6 | Coded sum after fault masks, registered |
| code_carry | output | 1 | Carry-out of the code adder, registered |
| dec_sum | output | 6 | Checked word divided by 3, registered |
| err | output | 1 | Checked word not divisible by 3 |
| ovf | output | 1 | Decoded sum above 15 |

## Verification
Fault detection and adder carry-out can act in the same cycle. The checker must then judge a 7-bit word whose top bit comes from the carry while its low bits are forced. If the carry were dropped, a wrapped sum would falsely look faulty, and a forced one could falsely look clean. The bench provokes this by running every operand pair, including those whose coded sum passes 63, under every single-bit stuck-at-0 and stuck-at-1 mask. For each case it computes the expected word, residue, quotient and overflow in plain integer arithmetic, and it compares every output field.

// File: rtl/an3_pkg.sv
package an3_pkg;

  localparam int unsigned CODE_MULT = 3;

  // Residue modulo 3 by weighted bit count: even index weighs 1, odd index 2 (= -1 mod 3).
  function automatic logic [1:0] mod3_of(input logic [31:0] v);
    logic [6:0] acc;
    acc = '0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) acc = acc + ((i % 2) == 1 ? 7'd2 : 7'd1);
    end
    for (int k = 0; k < 20; k++) begin
      if (acc >= 7'd3) acc = acc - 7'd3;
    end
    return acc[1:0];
  endfunction

  // Quotient by 3 with a restoring shift-subtract loop against a constant.
  function automatic logic [31:0] div3_of(input logic [31:0] v);
    logic [2:0]  r;
    logic [31:0] q;
    r = '0;
    q = '0;
    for (int i = 31; i >= 0; i--) begin
      r = {r[1:0], v[i]};
      if (r >= 3'd3) begin
        r    = r - 3'd3;
        q[i] = 1'b1;
      end
    end
    return q;
  endfunction

endpackage

// File: rtl/an3_encode.sv
module an3_encode #(
  parameter int DATA_W = 4,
  localparam int CODE_W = DATA_W + 2
) (
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] doubled;
  logic [CODE_W-1:0] single;

  // Twice the value by a shift, plus the value itself.
  assign doubled = {1'b0, data, 1'b0};
  assign single  = {2'b00, data};
  assign code    = doubled + single;
endmodule

// File: rtl/an3_fault_adder.sv
module an3_fault_adder #(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  input  logic [CODE_W-1:0] force0,
  input  logic [CODE_W-1:0] force1,
  output logic [CODE_W-1:0] raw_sum,
  output logic              carry,
  output logic [CODE_W-1:0] hit_sum
);
  logic [CODE_W:0] wide;

  assign wide    = {1'b0, code_a} + {1'b0, code_b};
  assign raw_sum = wide[CODE_W-1:0];
  assign carry   = wide[CODE_W];
  // Stuck-at-1 is applied last, so it wins over stuck-at-0 on the same bit.
  assign hit_sum = (raw_sum & ~force0) | force1;
endmodule

// File: rtl/an3_residue_check.sv
module an3_residue_check #(
  parameter int WORD_W = 7
) (
  input  logic [WORD_W-1:0] word,
  output logic [1:0]        residue,
  output logic              bad
);
  import an3_pkg::*;

  assign residue = mod3_of(32'(word));
  assign bad     = (residue != 2'd0);
endmodule

// File: rtl/an3_decode.sv
module an3_decode #(
  parameter int WORD_W = 7,
  parameter int OUT_W  = 6,
  parameter int DATA_W = 4
) (
  input  logic [WORD_W-1:0] word,
  output logic [OUT_W-1:0]  quotient,
  output logic              too_big
);
  import an3_pkg::*;

  logic [31:0] q_full;

  assign q_full   = div3_of(32'(word));
  assign quotient = q_full[OUT_W-1:0];
  // Any set bit at or above DATA_W means the result exceeds a data word.
  assign too_big  = |quotient[OUT_W-1:DATA_W];
endmodule

// File: rtl/an3_checked_adder.sv
module an3_checked_adder #(
  parameter int DATA_W = 4,
  localparam int CODE_W = DATA_W + 2,
  localparam int WORD_W = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [CODE_W-1:0] stuck0_mask,
  input  logic [CODE_W-1:0] stuck1_mask,
  output logic [CODE_W-1:0] code_sum,
  output logic              code_carry,
  output logic [CODE_W-1:0] dec_sum,
  output logic              err,
  output logic              ovf
);
  logic [CODE_W-1:0] code_a, code_b;
  logic [CODE_W-1:0] raw_sum, fault_sum;
  logic              sum_carry;
  logic [WORD_W-1:0] checked_word;
  logic [1:0]        residue;
  logic              residue_bad;
  logic [CODE_W-1:0] quotient;
  logic              quot_big;

  an3_encode #(.DATA_W(DATA_W)) u_enc_a (.data(op_a), .code(code_a));
  an3_encode #(.DATA_W(DATA_W)) u_enc_b (.data(op_b), .code(code_b));

  an3_fault_adder #(.CODE_W(CODE_W)) u_add (
    .code_a (code_a),
    .code_b (code_b),
    .force0 (stuck0_mask),
    .force1 (stuck1_mask),
    .raw_sum(raw_sum),
    .carry  (sum_carry),
    .hit_sum(fault_sum)
  );

  assign checked_word = {sum_carry, fault_sum};

  an3_residue_check #(.WORD_W(WORD_W)) u_chk (
    .word   (checked_word),
    .residue(residue),
    .bad    (residue_bad)
  );

  an3_decode #(.WORD_W(WORD_W), .OUT_W(CODE_W), .DATA_W(DATA_W)) u_dec (
    .word    (checked_word),
    .quotient(quotient),
    .too_big (quot_big)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_sum   <= '0;
      code_carry <= 1'b0;
      dec_sum    <= '0;
      err        <= 1'b0;
      ovf        <= 1'b0;
    end else begin
      code_sum   <= fault_sum;
      code_carry <= sum_carry;
      dec_sum    <= quotient;
      err        <= residue_bad;
      ovf        <= quot_big;
    end
  end

  // R3: a fault-free sum is always a multiple of three
  assert_clean_no_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stuck0_mask == '0 && stuck1_mask == '0) |=> !err);

  // R5: a one-bit change to the sum can never be a multiple of three
  assert_single_flip_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(raw_sum ^ fault_sum) == 1) |=> err);

  // R6: bits selected by stuck1_mask read back as ones
  assert_stuck1_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((code_sum & $past(stuck1_mask)) == $past(stuck1_mask)));

  // R7: whenever the flag is clear, three times the decoded sum rebuilds the code word
  assert_dec_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !err |-> (32'(dec_sum) * 32'd3 == 32'({code_carry, code_sum})));

  // R8: overflow follows the true data sum when no fault is injected
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stuck0_mask == '0 && stuck1_mask == '0) |=>
      (ovf == ((32'($past(op_a)) + 32'($past(op_b))) > 32'((1 << DATA_W) - 1))));
endmodule

// File: tb/sim_an3_checked_adder.sv
`timescale 1ns/1ps
module sim_an3_checked_adder;
  localparam real HALF = 2.5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] op_a, op_b;
  logic [5:0] stuck0_mask, stuck1_mask;
  logic [5:0] code_sum, dec_sum;
  logic       code_carry, err, ovf;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(HALF) clk = ~clk;

  an3_checked_adder #(.DATA_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .stuck0_mask(stuck0_mask), .stuck1_mask(stuck1_mask),
    .code_sum(code_sum), .code_carry(code_carry), .dec_sum(dec_sum),
    .err(err), .ovf(ovf)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (a=%0d b=%0d m0=%0h m1=%0h)",
               tag, act, exp, op_a, op_b, stuck0_mask, stuck1_mask);
    end
  endtask

  // Drive at a falling edge; the outputs load at the next rising edge and are read at the falling edge after.
  task automatic run_case(input int a, input int b, input int m0, input int m1,
                          input string code_tag, input string err_tag);
    int full, low, word, exp_err, exp_dec;
    @(negedge clk);
    op_a = 4'(a); op_b = 4'(b); stuck0_mask = 6'(m0); stuck1_mask = 6'(m1);
    @(negedge clk);
    full    = 3 * a + 3 * b;
    low     = ((full & 63) & ~m0 & 63) | m1;
    word    = ((full >> 6) & 1) * 64 + low;
    exp_err = (word % 3 != 0) ? 1 : 0;
    exp_dec = word / 3;
    check({code_tag, " code_sum"}, int'(code_sum), low);
    check({code_tag, " code_carry"}, int'(code_carry), (full >> 6) & 1);
    check(err_tag, int'(err), exp_err);
    check("R7 dec_sum", int'(dec_sum), exp_dec);
    check("R8 ovf", int'(ovf), (exp_dec > 15) ? 1 : 0);
  endtask

  initial begin
    rst_n = 1'b0;
    op_a = 4'd9; op_b = 4'd13; stuck0_mask = '0; stuck1_mask = 6'h15;
    repeat (3) @(negedge clk);
    // R9: reset holds every output at zero even with live inputs
    check("R9 reset code_sum", int'(code_sum), 0);
    check("R9 reset code_carry", int'(code_carry), 0);
    check("R9 reset dec_sum", int'(dec_sum), 0);
    check("R9 reset err", int'(err), 0);
    check("R9 reset ovf", int'(ovf), 0);
    rst_n = 1'b1;

    // R9: one-cycle latency - old value just before the edge, new value after
    run_case(2, 3, 0, 0, "R9", "R3 err");
    @(negedge clk);
    op_a = 4'd7; op_b = 4'd1; stuck0_mask = '0; stuck1_mask = '0;
    #1;
    check("R9 before edge", int'(code_sum), 15);
    @(negedge clk);
    check("R9 after edge", int'(code_sum), 24);

    // R1: encoding of each operand alone
    for (int a = 0; a < 16; a++) run_case(a, 0, 0, 0, "R1", "R3 err");
    check("R1 code of 15", int'(code_sum), 6'b101101);

    // R2 R3: every fault-free pair
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) run_case(a, b, 0, 0, "R2", "R3 err");

    // R4: worked example, 6 + 1 with bit 1 stuck at 1
    run_case(6, 1, 0, 2, "R4", "R4 err");
    check("R4 example word", int'(code_sum), 6'b010111);
    check("R4 example flag", int'(err), 1);

    // R5: every pair under every single-bit stuck-at mask, including wrapped sums
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int k = 0; k < 6; k++) begin
          int full_lo, bitv;
          full_lo = (3 * a + 3 * b) & 63;
          bitv    = (full_lo >> k) & 1;
          run_case(a, b, 1 << k, 0, "R6", bitv ? "R5 err" : "R4 err");
          run_case(a, b, 0, 1 << k, "R6", bitv ? "R4 err" : "R5 err");
        end

    // R6: stuck-at-1 wins on shared bits; the carry is never masked
    run_case(15, 15, 63, 63, "R6", "R4 err");
    check("R6 both masks", int'(code_sum), 63);
    run_case(15, 14, 63, 0, "R6", "R4 err");
    check("R6 carry unmasked", int'(code_carry), 1);
    check("R6 sum cleared", int'(code_sum), 0);

    // R8: boundary of the data range
    run_case(8, 7, 0, 0, "R2", "R3 err");
    check("R8 sum 15 no ovf", int'(ovf), 0);
    run_case(8, 8, 0, 0, "R2", "R3 err");
    check("R8 sum 16 ovf", int'(ovf), 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(HALF * 2.0 * 200000.0);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule